// File: doc/BRIEF.md
# Asymmetric-Sampled H-Bridge Gate Pulse Unit

This block drives one power cell of a cascaded H-bridge converter. It keeps two carrier counters, one per bridge leg. The two counters are mirror images of each other: in every half carrier period one counts up from zero while the other counts down from the half-period length. At each sync strobe they swap roles. Because the two legs share one compare value, a single duty sample placed each half period moves one edge on leg 1 and the opposite edge on leg 4 in the same half period. This is asymmetric regular sampling at no extra arithmetic cost.

A controller sends a signed width word together with a half flag on a load strobe. The block turns the word into a compare count and holds it in a shadow register. The next sync strobe commits the shadow value to both carriers and starts the half period that the flag names. The block outputs the two upper-switch pulses, their complements for the lower switches, and a copy of all four with a programmable turn-on delay (dead time) for the gate drivers.

Top module: `hb_pulse_unit`

## Requirements
- R1: After reset, all eight gate outputs stay low until the first clock edge at which `sync_valid` is high, even if load strobes arrive before then.
- R2: A load strobe computes the compare count C as floor((`half_len` − `load_duty`)/2). `load_duty` is read as a two's-complement number. C is clamped to 0 when the difference is negative and to `half_len` when the result exceeds `half_len`.
- R3: C and the half flag are held in a shadow stage. They take effect only at the next sync edge. A load strobe in the middle of a half period leaves the running half period unchanged.
- R4: Half flag 0 (first half) means leg 1 counts up and leg 4 counts down. `gate[0]` (P1) goes low C cycles after the sync edge; with C = 0 it goes low at the sync edge itself, and with C = `half_len` it does not change. `gate[3]` (P4) goes high `half_len` − C cycles after the sync edge; with C = 0 it does not change.
- R5: Half flag 1 (second half) means leg 4 counts up and leg 1 counts down. `gate[3]` goes low C cycles after the sync edge, and `gate[0]` goes high `half_len` − C cycles after it, with the same boundary cases as R4.
- R6: Outside the edges named in R4 and R5, P1 and P4 keep their level, including across half-period boundaries.
- R7: From the first sync edge onward, `gate[1]` (P2) is the inverse of `gate[0]` and `gate[2]` (P3) is the inverse of `gate[3]`.
- R8: Each bit of `gate_dt` goes low in the same cycle as its `gate` bit. It goes high only after that `gate` bit has been high for more than `dead_cycles` sampled cycles. With `dead_cycles` = 0, `gate_dt` equals `gate`.
- R9: `gate_dt[0]` and `gate_dt[1]` are never high together, and neither are `gate_dt[2]` and `gate_dt[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | Strobe that captures a new duty sample into the shadow stage |
| load_duty | input | DW | Signed pulse-width word used to derive the compare count |
| load_half | input | 1 | Half flag for the sample: 0 = first half, 1 = second half |
| sync_valid | input | 1 | Sync strobe that starts a half period and commits the shadow stage |
| half_len | input | CW | Half carrier period in clock cycles (at least 3) |
| dead_cycles | input | DTW | Turn-on delay in clock cycles |
| gate | output | 4 | Undelayed pulses: bit 0 = P1, bit 1 = P2, bit 2 = P3, bit 3 = P4 |
| gate_dt | output | 4 | Same four pulses with dead time applied to turn-on edges |

## Verification
The checker watches every cycle for four things: the outputs stay silent before the first sync, the two switches of a leg are never on together after dead-time insertion, a turn-off edge on a delayed output arrives in the same cycle as on the raw pulse, and a turn-on edge on a delayed output never arrives before the raw pulse has been high. The edge positions within each half period cannot be shown by per-cycle properties. Those are the compare arithmetic with its clamping, the mirrored up/down roles, the shadow commit at sync, and the exact dead-time length. The bench shows them by sweeping the width word across both saturation limits, for several half-period lengths and dead times, with an alternating and sometimes repeated half flag.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } half_e;

    typedef struct packed {
        logic     live;
        cnt_dir_e dir;
        logic     pulse;
    } car_flags_t;

    localparam int GATE_N = 4;

endpackage

// File: rtl/hbp_cmpcalc.sv
module hbp_cmpcalc #(
    parameter int CW = 8,
    parameter int DW = 10
) (
    input  logic [CW-1:0] half_len,
    input  logic [DW-1:0] duty,
    output logic [CW-1:0] cmp
);
    localparam int SW = ((CW > DW) ? CW : DW) + 2;

    logic signed [SW-1:0] hl_ext;
    logic signed [SW-1:0] diff;
    logic signed [SW-1:0] halved;

    always_comb begin
        hl_ext = $signed({{(SW-CW){1'b0}}, half_len});
        diff   = hl_ext - $signed({{(SW-DW){duty[DW-1]}}, duty});
        halved = diff >>> 1;
        if (diff < 0)
            cmp = '0;
        else if (halved > hl_ext)
            cmp = half_len;
        else
            cmp = halved[CW-1:0];
    end
endmodule

// File: rtl/hbp_carrier.sv
module hbp_carrier
    import hbp_pkg::*;
#(
    parameter int CW      = 8,
    parameter bit UP_HALF = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync,
    input  logic          half,
    input  logic [CW-1:0] cmp_in,
    input  logic [CW-1:0] half_len,
    output logic          pulse,
    output logic          live
);
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] cmp_q, cmp_d;
    car_flags_t    flg_q, flg_d;
    logic [CW-1:0] top_val;
    logic          goes_up;

    always_comb begin
        top_val = half_len - CW'(1);
        goes_up = (half == UP_HALF);
        cnt_d   = cnt_q;
        cmp_d   = cmp_q;
        flg_d   = flg_q;
        if (sync) begin
            flg_d.live = 1'b1;
            flg_d.dir  = goes_up ? DIR_UP : DIR_DOWN;
            cnt_d      = goes_up ? '0 : half_len;
            cmp_d      = cmp_in;
        end else if (flg_q.live) begin
            if (flg_q.dir == DIR_UP) begin
                if (cnt_q < top_val) cnt_d = cnt_q + CW'(1);
            end else begin
                if (cnt_q > CW'(1)) cnt_d = cnt_q - CW'(1);
            end
        end
        if (flg_d.live && (cnt_d == cmp_d))
            flg_d.pulse = (flg_d.dir == DIR_DOWN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cmp_q <= '0;
            flg_q <= '{live: 1'b0, dir: DIR_UP, pulse: 1'b0};
        end else begin
            cnt_q <= cnt_d;
            cmp_q <= cmp_d;
            flg_q <= flg_d;
        end
    end

    assign pulse = flg_q.pulse;
    assign live  = flg_q.live;
endmodule

// File: rtl/hbp_deadtime.sv
module hbp_deadtime #(
    parameter int DTW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           raw,
    input  logic [DTW-1:0] dead,
    output logic           out
);
    logic [DTW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (!raw)
            held_q <= '0;
        else if (held_q < dead)
            held_q <= held_q + DTW'(1);
    end

    assign out = raw && (held_q >= dead);
endmodule

// File: rtl/hb_pulse_unit.sv
module hb_pulse_unit
    import hbp_pkg::*;
#(
    parameter int CW  = 8,
    parameter int DW  = 10,
    parameter int DTW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_valid,
    input  logic [DW-1:0]  load_duty,
    input  logic           load_half,
    input  logic           sync_valid,
    input  logic [CW-1:0]  half_len,
    input  logic [DTW-1:0] dead_cycles,
    output logic [3:0]     gate,
    output logic [3:0]     gate_dt
);
    localparam int LEGS = 2;

    logic [CW-1:0]   cmp_calc;
    logic [CW-1:0]   shadow_cmp;
    half_e           shadow_half;
    logic [LEGS-1:0] leg_pulse;
    logic [LEGS-1:0] leg_live;
    logic            run;

    hbp_cmpcalc #(.CW(CW), .DW(DW)) u_calc (
        .half_len (half_len),
        .duty     (load_duty),
        .cmp      (cmp_calc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_cmp  <= '0;
            shadow_half <= HALF_FIRST;
        end else if (load_valid) begin
            shadow_cmp  <= cmp_calc;
            shadow_half <= half_e'(load_half);
        end
    end

    // leg 0 carries P1 (up in first half), leg 1 carries P4 (up in second half)
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        hbp_carrier #(.CW(CW), .UP_HALF(g == 1)) u_car (
            .clk      (clk),
            .rst      (rst),
            .sync     (sync_valid),
            .half     (shadow_half),
            .cmp_in   (shadow_cmp),
            .half_len (half_len),
            .pulse    (leg_pulse[g]),
            .live     (leg_live[g])
        );
    end

    assign run  = &leg_live;
    assign gate = {leg_pulse[1], run & ~leg_pulse[1], run & ~leg_pulse[0], leg_pulse[0]};

    for (genvar k = 0; k < GATE_N; k++) begin : g_dt
        hbp_deadtime #(.DTW(DTW)) u_dt (
            .clk  (clk),
            .rst  (rst),
            .raw  (gate[k]),
            .dead (dead_cycles),
            .out  (gate_dt[k])
        );
    end
endmodule

// File: rtl/hbp_checker.sv
module hbp_checker #(
    parameter int DTW = 6
) (
    input logic           clk,
    input logic           rst,
    input logic           sync_valid,
    input logic [DTW-1:0] dead_cycles,
    input logic [3:0]     gate,
    input logic [3:0]     gate_dt
);
    logic started;

    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else if (sync_valid) started <= 1'b1;
    end

    a_r1_idle_until_sync: assert property (@(posedge clk) disable iff (rst)
        !started |-> (gate == 4'b0 && gate_dt == 4'b0));

    a_r8_off_immediate: assert property (@(posedge clk) disable iff (rst)
        (gate_dt & ~gate) == 4'b0);

    a_r8_on_delayed: assert property (@(posedge clk) disable iff (rst)
        (dead_cycles != '0) |-> ((gate_dt & ~$past(gate_dt) & ~$past(gate)) == 4'b0));

    a_r8_zero_dead_pass: assert property (@(posedge clk) disable iff (rst)
        (dead_cycles == '0) |-> (gate_dt == gate));

    a_r9_leg1_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gate_dt[0] && gate_dt[1]));

    a_r9_leg2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gate_dt[2] && gate_dt[3]));
endmodule

bind hb_pulse_unit hbp_checker #(.DTW(DTW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_valid  (sync_valid),
    .dead_cycles (dead_cycles),
    .gate        (gate),
    .gate_dt     (gate_dt)
);

// File: tb/sim_hb_pulse_unit.sv
module sim_hb_pulse_unit;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 8;
    localparam int DW  = 10;
    localparam int DTW = 6;

    logic           clk = 1'b0;
    logic           rst;
    logic           load_valid;
    logic [DW-1:0]  load_duty;
    logic           load_half;
    logic           sync_valid;
    logic [CW-1:0]  half_len;
    logic [DTW-1:0] dead_cycles;
    logic [3:0]     gate;
    logic [3:0]     gate_dt;

    int   vectors = 0;
    int   miscompares = 0;
    int   hc [4];
    int   cur_h;
    int   cur_dt;
    logic lvl1, lvl4, started;
    logic [3:0] exp_g, exp_d;

    hb_pulse_unit #(.CW(CW), .DW(DW), .DTW(DTW)) u0 (
        .clk(clk), .rst(rst), .load_valid(load_valid), .load_duty(load_duty),
        .load_half(load_half), .sync_valid(sync_valid), .half_len(half_len),
        .dead_cycles(dead_cycles), .gate(gate), .gate_dt(gate_dt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // R2: compare count from width word, clamped to [0, H]
    function automatic int ref_cmp(int h, int w);
        int t;
        int c;
        t = h - w;
        if (t < 0) return 0;
        c = t / 2;
        if (c > h) c = h;
        return c;
    endfunction

    task automatic check_now(input string hint, input bit second);
        string tag;
        exp_g = started ? {lvl4, ~lvl4, ~lvl1, lvl1} : 4'b0;
        for (int i = 0; i < 4; i++) begin
            if (exp_g[i]) hc[i]++;
            else hc[i] = 0;
            exp_d[i] = exp_g[i] && (hc[i] > cur_dt);
        end
        vectors++;
        if ({gate_dt, gate} !== {exp_d, exp_g}) begin
            miscompares++;
            if (hint != "") tag = hint;
            else if ((gate[0] !== exp_g[0]) || (gate[3] !== exp_g[3])) tag = second ? "R5" : "R4";
            else if (gate !== exp_g) tag = "R7";
            else tag = "R8";
            $display("FAIL %s: H=%0d dt=%0d gate=%b gate_dt=%b expected gate=%b gate_dt=%b",
                     tag, cur_h, cur_dt, gate, gate_dt, exp_g, exp_d);
        end
    endtask

    task automatic do_reset(input int h, input int dt);
        cur_h = h;
        cur_dt = dt;
        rst = 1'b1;
        load_valid = 1'b0;
        load_duty = '0;
        load_half = 1'b0;
        sync_valid = 1'b0;
        half_len = CW'(h);
        dead_cycles = DTW'(dt);
        lvl1 = 1'b0;
        lvl4 = 1'b0;
        started = 1'b0;
        for (int i = 0; i < 4; i++) hc[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one half period: sync at the next edge, then H samples
    task automatic run_half(input int c, input bit hf, input int nw, input bit nhf);
        sync_valid = 1'b1;
        started = 1'b1;
        for (int p = 0; p < cur_h; p++) begin
            @(negedge clk);
            sync_valid = 1'b0;
            load_valid = 1'b0;
            if (!hf) begin
                if (p >= c) lvl1 = 1'b0;          // R4 up-counting leg 1
                if (p >= cur_h - c) lvl4 = 1'b1;  // R4 down-counting leg 4
            end else begin
                if (p >= c) lvl4 = 1'b0;          // R5 up-counting leg 4
                if (p >= cur_h - c) lvl1 = 1'b1;  // R5 down-counting leg 1
            end
            // R6: levels otherwise carried over; R7/R8/R9 via vector compare
            check_now("", hf);
            if (p == 0) begin
                // R3: a mid-period load must not disturb the running half
                load_valid = 1'b1;
                load_duty = DW'(-2 * cur_h - 5);
                load_half = ~nhf;
            end
            if (p == cur_h - 2) begin
                load_valid = 1'b1;
                load_duty = nw[DW-1:0];
                load_half = nhf;
            end
        end
    endtask

    task automatic run_config(input int h, input int dt);
        int  cw;
        bit  chf;
        int  nw;
        bit  nhf;
        int  nsteps;
        do_reset(h, dt);
        // R1: idle with load strobes before the first sync
        for (int k = 0; k < 6; k++) begin
            load_valid = k[0];
            load_duty = DW'(k - 3);
            load_half = k[1];
            @(negedge clk);
            check_now("R1", 1'b0);
        end
        cw = -2 * h - 2;
        chf = 1'b0;
        load_valid = 1'b1;
        load_duty = cw[DW-1:0];
        load_half = chf;
        @(negedge clk);
        load_valid = 1'b0;
        check_now("R1", 1'b0);
        nsteps = 4 * h + 5;
        for (int j = 1; j <= nsteps; j++) begin
            nw = -2 * h - 2 + j;
            nhf = ((j % 4) == 3) ? chf : ~chf;
            run_half(ref_cmp(h, cw), chf, nw, nhf);
            cw = nw;
            chf = nhf;
        end
    endtask

    initial begin
        run_config(8, 2);
        run_config(5, 0);
        run_config(6, 7);
        run_config(3, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule